// File: doc/BRIEF.md
# PCI Interrupt Mapping Autodetect Router

This block sits beside a PCI host bridge and folds the level INTx requests of a group of slots onto four system interrupt lines. Two routings exist. One passes pin n straight to line n, for old guest software that assumed that wiring. The other rotates each pin by its slot number, which is how the board is really wired. The block has to choose between them at run time without help from software.

To choose, it watches configuration writes from the host. While its mode is still undecided, the first write to a device's interrupt-line register is compared against the values that known faulty guests write for that slot. The verdict, either broken or confirmed good, is then locked until reset. A mode value applied during reset can preset the verdict. An alternate board variant turns detection off and always uses a rotation that is one step further round. The block only observes configuration traffic. It does not forward it.

Top module: `pci_irq_autoroute`

## Requirements
- R1: While `rst_n` is low, `mode` takes the value of `init_mode`. The encoding is 0 = undecided (assume-ok), 1 = broken, 2 = confirmed good (force-ok). An `init_mode` of 3 loads 0.
- R2: The mode is re-evaluated only on a rising clock edge where all of these hold: `cfg_wr_en` is 1, `alt_variant` is 0, `cfg_addr[7:0]` is 0x3C and `mode` is 0. Any other write leaves `mode` unchanged.
- R3: The slot used for classification is the device number `cfg_addr[15:11]` reduced modulo 4, which is `cfg_addr[12:11]`. The function bits `cfg_addr[10:8]` are ignored.
- R4: A written value of 27 keeps `mode` at 0 when the slot modulo 4 is 2, and sets `mode` to 1 for any other slot.
- R5: A value equal to slot+27 or slot+91 sets `mode` to 1. Any value not covered by R4 or R5 sets `mode` to 2.
- R6: Once `mode` is 1 or 2, it holds that value until the next reset.
- R7: When `mode` is 1 and `alt_variant` is 0, request pin p of every slot drives `irq_out[p]`.
- R8: In every other case, pin p of slot index i goes to output (FIRST_SLOT+i+p+k) mod 4, where k is 2 when `alt_variant` is 0 and 3 when it is 1. Slot index i, pin p is bit `irq_req[4*i+p]`. For example, device 31 INTA goes to output 1 on the primary variant and to output 2 on the alternate variant.
- R9: Each `irq_out` bit is the OR of every request routed to it. It follows `irq_req` within the same cycle, and with no requests every output is 0.
- R10: A mode change caused by a write appears on `mode`, and in the routing, just after the clock edge that samples that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alt_variant | input | 1 | 1 selects the alternate board wiring (no detection, k=3) |
| init_mode | input | 2 | Mode loaded during reset |
| cfg_wr_en | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | ADDR_W (24) | Configuration address: [15:8] device/function, [7:0] register offset |
| cfg_wdata | input | DATA_W (32) | Configuration write data |
| irq_req | input | 4*NUM_SLOTS (16) | Level INTA..INTD requests, four bits per slot |
| irq_out | output | 4 | System interrupt lines |
| mode | output | 2 | Current mapping mode |

## Verification
The assertions assume that `alt_variant` stays constant between resets and that `init_mode` is stable while reset is active. The bench changes either one only inside its reset task. Write strobes are single-cycle pulses driven on the falling edge, with no address or data changes while a strobe is high. Random addresses mix interrupt-line hits with other offsets. Random data is drawn from the signature values of the current slot and from arbitrary bytes, so that all three verdicts and the slot-2 exception come up.

// File: rtl/pci_irqmap_pkg.sv
package pci_irqmap_pkg;

  typedef enum logic [1:0] {
    MODE_ASSUME = 2'd0,
    MODE_BROKEN = 2'd1,
    MODE_FORCE  = 2'd2
  } irqmap_mode_e;

  localparam int unsigned   PINS        = 4;
  localparam logic [7:0]    INTLINE_OFS = 8'h3C;
  localparam int unsigned   SIG_BASE    = 27;
  localparam int unsigned   SIG_HIGH    = 64;

  // Reset value decode: unused code 3 falls back to undecided.
  function automatic irqmap_mode_e decode_init(logic [1:0] v);
    case (v)
      2'd1:    return MODE_BROKEN;
      2'd2:    return MODE_FORCE;
      default: return MODE_ASSUME;
    endcase
  endfunction

  // Verdict on a value written to a slot's interrupt-line register.
  function automatic irqmap_mode_e classify(logic [1:0] slot4, logic [31:0] val);
    logic [31:0] low_sig;
    logic [31:0] high_sig;
    low_sig  = SIG_BASE + 32'(slot4);
    high_sig = low_sig + SIG_HIGH;
    if (val == SIG_BASE)
      return (slot4 == 2'd2) ? MODE_ASSUME : MODE_BROKEN;
    if (val == low_sig || val == high_sig)
      return MODE_BROKEN;
    return MODE_FORCE;
  endfunction

  // Output line for one request pin.
  function automatic logic [1:0] route_index(int unsigned dev, logic [1:0] pin,
                                             logic alt, logic pass_thru);
    int unsigned rot;
    if (pass_thru) return pin;
    rot = alt ? 3 : 2;
    return 2'((dev + 32'(pin) + rot) % PINS);
  endfunction

endpackage

// File: rtl/irqmap_detector.sv
module irqmap_detector
  import pci_irqmap_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_variant,
  input  logic [1:0]        init_mode,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output irqmap_mode_e      mode_q
);

  logic [7:0]   reg_ofs;
  logic [4:0]   dev_num;
  logic         snoop_hit;
  irqmap_mode_e verdict;

  assign reg_ofs   = cfg_addr[7:0];
  assign dev_num   = cfg_addr[15:11];
  assign snoop_hit = cfg_wr_en && !alt_variant && (reg_ofs == INTLINE_OFS)
                     && (mode_q == MODE_ASSUME);
  assign verdict   = classify(dev_num[1:0], 32'(cfg_wdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= decode_init(init_mode);
    else if (snoop_hit) mode_q <= verdict;
  end

  // R6: a settled verdict never moves
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_ASSUME) |=> (mode_q == $past(mode_q)));

  // R2: without a qualifying write the mode is frozen
  assert_no_snoop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !snoop_hit |=> $stable(mode_q));

  // R10: a qualifying write lands its verdict on the next cycle
  assert_verdict_R10: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_hit |=> (mode_q == $past(verdict)));

  // R1: the unused code never appears
  assert_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'd3);

endmodule

// File: rtl/irqmap_router.sv
module irqmap_router
  import pci_irqmap_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int FIRST_SLOT = 28
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alt_variant,
  input  irqmap_mode_e              mode,
  input  logic [PINS*NUM_SLOTS-1:0] irq_req,
  output logic [PINS-1:0]           irq_out
);

  localparam int REQ_W = PINS * NUM_SLOTS;

  logic             pass_thru;
  logic [REQ_W-1:0] sel_mask [PINS];

  assign pass_thru = (mode == MODE_BROKEN) && !alt_variant;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    for (genvar p = 0; p < PINS; p++) begin : g_pin
      logic [1:0] dest;
      assign dest = route_index(FIRST_SLOT + s, 2'(p), alt_variant, pass_thru);
      for (genvar o = 0; o < PINS; o++) begin : g_out
        assign sel_mask[o][s*PINS+p] = (dest == 2'(o));
      end
      // R8: every request reaches exactly one line
      assert_one_dest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel_mask[3][s*PINS+p], sel_mask[2][s*PINS+p],
                    sel_mask[1][s*PINS+p], sel_mask[0][s*PINS+p]}) == 1);
    end
  end

  for (genvar o = 0; o < PINS; o++) begin : g_or
    assign irq_out[o] = |(irq_req & sel_mask[o]);
  end

  // R9: quiet inputs give quiet outputs
  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req == '0) |-> (irq_out == '0));

  // R9: merging can only reduce the number of active lines
  assert_merge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= $countones(irq_req));

endmodule

// File: rtl/pci_irq_autoroute.sv
module pci_irq_autoroute
  import pci_irqmap_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 32,
  parameter int NUM_SLOTS  = 4,
  parameter int FIRST_SLOT = 28
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alt_variant,
  input  logic [1:0]              init_mode,
  input  logic                    cfg_wr_en,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [DATA_W-1:0]       cfg_wdata,
  input  logic [4*NUM_SLOTS-1:0]  irq_req,
  output logic [3:0]              irq_out,
  output logic [1:0]              mode
);

  irqmap_mode_e mode_q;

  irqmap_detector #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) det_i (
    .clk(clk), .rst_n(rst_n), .alt_variant(alt_variant), .init_mode(init_mode),
    .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mode_q(mode_q)
  );

  irqmap_router #(.NUM_SLOTS(NUM_SLOTS), .FIRST_SLOT(FIRST_SLOT)) rte_i (
    .clk(clk), .rst_n(rst_n), .alt_variant(alt_variant), .mode(mode_q),
    .irq_req(irq_req), .irq_out(irq_out)
  );

  assign mode = mode_q;

  // R7: pass-through sends a lone request to its own pin number
  assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_BROKEN && !alt_variant && irq_req == 16'h0001) |-> (irq_out == 4'b0001));

endmodule

// File: tb/pci_irq_autoroute_tb_top.sv
module pci_irq_autoroute_tb_top;

  localparam int NS = 4;
  localparam int FS = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alt_variant = 1'b0;
  logic [1:0]  init_mode = 2'd0;
  logic        cfg_wr_en = 1'b0;
  logic [23:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [15:0] irq_req = '0;
  logic [3:0]  irq_out;
  logic [1:0]  mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pci_irq_autoroute dut_i (
    .clk(clk), .rst_n(rst_n), .alt_variant(alt_variant), .init_mode(init_mode),
    .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .irq_req(irq_req), .irq_out(irq_out), .mode(mode)
  );

  function automatic logic [1:0] exp_verdict(int slot, int unsigned v);
    int s = slot % 4;
    if (v == 27) return (s == 2) ? 2'd0 : 2'd1;
    if (v == 27 + s || v == 91 + s) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [3:0] exp_route(logic [15:0] req, logic [1:0] m, logic alt);
    logic [3:0] r = '0;
    for (int i = 0; i < NS; i++)
      for (int p = 0; p < 4; p++)
        if (req[i*4+p]) begin
          if (m == 2'd1 && !alt) r[p] = 1'b1;
          else r[(FS + i + p + (alt ? 3 : 2)) % 4] = 1'b1;
        end
    return r;
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [1:0] im, logic alt);
    @(negedge clk);
    rst_n = 1'b0; init_mode = im; alt_variant = alt;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg_write(logic [4:0] dev, logic [2:0] fn, logic [7:0] ofs, logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = {8'h00, dev, fn, ofs}; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic check_routes(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      irq_req = 16'($urandom);
      #2;
      check("R8/R9 route", irq_out, exp_route(irq_req, mode, alt_variant));
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1 reset values
    for (int v = 0; v < 4; v++) begin
      do_reset(2'(v), 1'b0);
      check("R1 reset mode", {2'b0, mode}, (v == 3) ? 4'd0 : 4'(v));
    end
    do_reset(2'd0, 1'b0);
    @(negedge clk); irq_req = '0; #2;
    check("R9 quiet", irq_out, 4'h0);
    // R8 example: device 31 INTA
    @(negedge clk); irq_req = 16'h1000; #2;
    check("R8 dev31 primary", irq_out, 4'b0010);
    do_reset(2'd0, 1'b1);
    @(negedge clk); #2;
    check("R8 dev31 alt", irq_out, 4'b0100);
    // R2 alt variant never detects
    cfg_write(5'd3, 3'd0, 8'h3C, 32'd30);
    check("R2 alt no detect", {2'b0, mode}, 4'd0);
    // R2 wrong offset ignored
    do_reset(2'd0, 1'b0);
    cfg_write(5'd1, 3'd0, 8'h3D, 32'd28);
    check("R2 offset ignored", {2'b0, mode}, 4'd0);
    // R4 slot-2 exception, function bits ignored (R3)
    cfg_write(5'd6, 3'd5, 8'h3C, 32'd27);
    check("R4 slot2 value27", {2'b0, mode}, 4'd0);
    cfg_write(5'd13, 3'd7, 8'h3C, 32'd92);
    check("R3/R5 high sig", {2'b0, mode}, 4'd1);
    // R6 sticky, R7 pass-through
    cfg_write(5'd0, 3'd0, 8'h3C, 32'd5);
    check("R6 sticky broken", {2'b0, mode}, 4'd1);
    @(negedge clk); irq_req = 16'h8421; #2;
    check("R7 pass-through", irq_out, 4'hF);
    @(negedge clk); irq_req = 16'h0002; #2;
    check("R7 pin1", irq_out, 4'b0010);
    // R10/R5 force-ok, sticky
    do_reset(2'd0, 1'b0);
    cfg_write(5'd0, 3'd0, 8'h3C, 32'd100);
    check("R10/R5 force", {2'b0, mode}, 4'd2);
    cfg_write(5'd1, 3'd0, 8'h3C, 32'd27);
    check("R6 sticky force", {2'b0, mode}, 4'd2);
    // Random
    for (int it = 0; it < 60; it++) begin
      logic alt; logic [4:0] dev; logic [7:0] ofs; logic [31:0] d; logic [1:0] em;
      int sel;
      alt = ($urandom % 5) == 0;
      do_reset(2'd0, alt);
      dev = 5'($urandom);
      ofs = (($urandom % 4) != 0) ? 8'h3C : 8'($urandom);
      sel = $urandom % 4;
      d = (sel == 0) ? 32'd27 : (sel == 1) ? 32'(27 + dev % 4) :
          (sel == 2) ? 32'(91 + dev % 4) : 32'($urandom % 256);
      cfg_write(dev, 3'($urandom), ofs, d);
      em = (alt || ofs != 8'h3C) ? 2'd0 : exp_verdict(int'(dev), d);
      check("R2/R4/R5 random verdict", {2'b0, mode}, {2'b0, em});
      if (em != 2'd0) begin
        cfg_write(5'($urandom), 3'd0, 8'h3C, 32'($urandom % 128));
        check("R6 random sticky", {2'b0, mode}, {2'b0, em});
      end
      check_routes(3);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule